// File: doc/BRIEF.md
# Memory Bus Access Gate with Supply-Fail Lockout

This block sits between an asynchronous-style external bus (active-low chip enable, write enable and output enable, an address and a data bus) and an internal storage-plus-timekeeping array. It turns the bus pin states into single-clock read and write strobes for the array. It also produces the output-drive control for the bidirectional data pins. Pin-level nanosecond timing is replaced by a registered, synchronous model in which every interval is a count of clock edges.

A write is a window in which chip enable and write enable are both low. It opens when the later of the two goes low. It commits to the array exactly once, on the edge where the window closes. After each committed write, a bus access must wait out a recovery interval of `REC_CYC` edges. An access that begins too early is refused and reported on `acc_err`.

While `pwr_fail` is high, chip enable is masked internally, any open write is dropped without a commit, and the active-low `rst_out_n` output is held low until the supply is good again.

Top module: `nvbus_gate`

## Requirements
- R1: When chip enable is low, write enable is high, `pwr_fail` is low and the access was not refused, `arr_rd` is high on the next clock and `arr_addr` then holds the `addr` value sampled at that edge; `dq_out` always equals `arr_rdata`.
- R2: `dq_oe` is high on a clock only if, at the edge before it, chip enable and output enable were low, write enable was high, `pwr_fail` was low and the access was accepted.
- R3: When write enable goes low during a driven read, `dq_oe` is low from the next clock, whatever output enable does.
- R4: A write window opens when the later of chip enable and write enable falls. On the first edge at which the window is seen closed, `arr_wr` pulses high for exactly one clock, with `arr_addr` and `arr_wdata` taken from `addr` and `din` at that edge. Exactly one array write results per window.
- R5: An access that starts (chip enable falls, or write enable toggles while chip enable is low) on the commit edge or on any of the next `REC_CYC`-1 edges is refused. `acc_err` pulses high for one clock, and no strobe or data drive occurs until chip enable goes high again.
- R6: An access that starts on the `REC_CYC`-th edge after the commit edge, or later, is accepted normally.
- R7: If `addr` changes while a read is driven, `dq_out` shows the old location until the next edge and the new location after it.
- R8: While `pwr_fail` is high, chip enable is treated as inactive: from the next clock, `arr_rd`, `arr_wr` and `dq_oe` stay low.
- R9: A write window still open when `pwr_fail` rises is discarded: no `arr_wr` pulse, and the location keeps its old contents.
- R10: `rst_out_n` is low on the clock after any edge that samples `pwr_fail` high, and high on the clock after an edge that samples it low.
- R11: During reset, `arr_rd`, `arr_wr`, `dq_oe` and `acc_err` are low and `rst_out_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pwr_fail | input | 1 | Supply below fail threshold |
| addr | input | AW | Bus address |
| din | input | DW | Data from the bus pins |
| dq_out | output | DW | Data toward the bus pins |
| dq_oe | output | 1 | Drive enable for the data pins |
| arr_addr | output | AW | Array address |
| arr_rd | output | 1 | Array read strobe |
| arr_wr | output | 1 | Array write strobe, one clock per write |
| arr_wdata | output | DW | Array write data |
| arr_rdata | input | DW | Array read data for `arr_addr` |
| acc_err | output | 1 | Early-access refusal pulse |
| rst_out_n | output | 1 | Active-low reset out during supply fail |

## Verification
Every result is one register away from the bus pins. The bench therefore changes inputs on the falling clock edge and samples the matching outputs on the next falling edge, one full cycle later. This covers `dq_oe`, `arr_rd`, the `arr_wr` commit pulse, `acc_err` and `rst_out_n`. The one combinational path, `arr_rdata` to `dq_out`, is sampled just after an address change and before the next edge, to show that the old data is still there (R7). Recovery boundaries are counted from the edge that samples the write window closed: an access driven `REC_CYC`-1 falling edges after the end must be refused, and one driven `REC_CYC` falling edges after it must be accepted.

// File: rtl/nvbg_pkg.sv
package nvbg_pkg;

   // Decoded bus state for one clock
   typedef struct packed {
      logic ce_eff;    // chip enable after supply-fail masking
      logic wr_raw;    // write mode seen on the pins
      logic start;     // a new access begins on this edge
      logic early;     // that start falls inside the recovery window
      logic lock_nxt;  // refused-cycle lock for the next clock
      logic rd_now;    // accepted read mode
      logic wr_now;    // accepted write mode
   } nvbg_dec_t;

endpackage

// File: rtl/nvbg_decode.sv
module nvbg_decode
   import nvbg_pkg::*;
(
   input  logic      ce_n,
   input  logic      we_n,
   input  logic      pwr_fail,
   input  logic      ce_q,
   input  logic      we_q,
   input  logic      lock_q,
   input  logic      busy,
   input  logic      commit_now,
   output nvbg_dec_t dec
);

   always_comb begin
      dec.ce_eff   = ~ce_n & ~pwr_fail;
      dec.wr_raw   = dec.ce_eff & ~we_n;
      // chip enable falling, or write enable toggling under chip enable
      dec.start    = dec.ce_eff & (~ce_q | (we_n ^ we_q));
      dec.early    = dec.start & (busy | commit_now);
      dec.lock_nxt = dec.ce_eff & (dec.early | lock_q);
      dec.rd_now   = dec.ce_eff & we_n & ~dec.lock_nxt;
      dec.wr_now   = dec.wr_raw & ~dec.lock_nxt;
   end

endmodule

// File: rtl/nvbg_recovery.sv
module nvbg_recovery #(
   parameter int REC_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic commit_now,
   output logic busy
);

   generate
      if (REC_CYC < 1) begin : g_bad_rec
         $error("nvbg_recovery: REC_CYC must be at least 1");
      end

      if (REC_CYC == 1) begin : g_edge_only
         // only the commit edge itself is blocked, handled in decode
         assign busy = 1'b0;
      end else begin : g_counter
         localparam int CW = $clog2(REC_CYC);
         localparam logic [CW-1:0] LOADV = CW'(REC_CYC - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (commit_now) begin
               cnt <= LOADV;
            end else if (cnt != '0) begin
               cnt <= cnt - 1'b1;
            end
         end

         assign busy = (cnt != '0);
      end
   endgenerate

endmodule

// File: rtl/nvbg_wrctl.sv
module nvbg_wrctl #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_now,
   input  logic          wr_raw,
   input  logic          pwr_fail,
   input  logic [DW-1:0] din,
   output logic          commit_now,
   output logic          arr_wr,
   output logic [DW-1:0] arr_wdata
);

   logic wr_q;

   // window closes without a supply fault: commit
   assign commit_now = wr_q & ~wr_raw & ~pwr_fail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q      <= 1'b0;
         arr_wr    <= 1'b0;
         arr_wdata <= '0;
      end else begin
         wr_q   <= wr_now;
         arr_wr <= commit_now;
         if (commit_now) begin
            arr_wdata <= din;
         end
      end
   end

endmodule

// File: rtl/nvbus_gate.sv
module nvbus_gate
   import nvbg_pkg::*;
#(
   parameter int AW      = 13,
   parameter int DW      = 8,
   parameter int REC_CYC = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic          pwr_fail,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dq_out,
   output logic          dq_oe,
   output logic [AW-1:0] arr_addr,
   output logic          arr_rd,
   output logic          arr_wr,
   output logic [DW-1:0] arr_wdata,
   input  logic [DW-1:0] arr_rdata,
   output logic          acc_err,
   output logic          rst_out_n
);

   generate
      if (AW < 1) begin : g_bad_aw
         $error("nvbus_gate: AW must be positive");
      end
      if (DW < 1) begin : g_bad_dw
         $error("nvbus_gate: DW must be positive");
      end
   endgenerate

   nvbg_dec_t dec;
   logic      ce_q;
   logic      we_q;
   logic      lock_q;
   logic      busy;
   logic      commit_now;

   nvbg_decode i_decode (
      .ce_n       (ce_n),
      .we_n       (we_n),
      .pwr_fail   (pwr_fail),
      .ce_q       (ce_q),
      .we_q       (we_q),
      .lock_q     (lock_q),
      .busy       (busy),
      .commit_now (commit_now),
      .dec        (dec)
   );

   nvbg_recovery #(.REC_CYC(REC_CYC)) i_recovery (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_now (commit_now),
      .busy       (busy)
   );

   nvbg_wrctl #(.DW(DW)) i_wrctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_now     (dec.wr_now),
      .wr_raw     (dec.wr_raw),
      .pwr_fail   (pwr_fail),
      .din        (din),
      .commit_now (commit_now),
      .arr_wr     (arr_wr),
      .arr_wdata  (arr_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q      <= 1'b0;
         we_q      <= 1'b1;
         lock_q    <= 1'b0;
         arr_addr  <= '0;
         arr_rd    <= 1'b0;
         dq_oe     <= 1'b0;
         acc_err   <= 1'b0;
         rst_out_n <= 1'b0;
      end else begin
         ce_q      <= dec.ce_eff;
         we_q      <= we_n;
         lock_q    <= dec.lock_nxt;
         arr_addr  <= addr;
         arr_rd    <= dec.rd_now;
         dq_oe     <= dec.rd_now & ~oe_n;
         acc_err   <= dec.early;
         rst_out_n <= ~pwr_fail;
      end
   end

   assign dq_out = arr_rdata;

endmodule

// File: rtl/nvbg_chk.sv
module nvbg_chk (
   input logic clk,
   input logic rst_n,
   input logic ce_n,
   input logic we_n,
   input logic oe_n,
   input logic pwr_fail,
   input logic dq_oe,
   input logic arr_rd,
   input logic arr_wr,
   input logic acc_err,
   input logic rst_out_n
);

   a_r1_read_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      arr_rd |-> $past(!ce_n && we_n && !pwr_fail));

   a_r2_drive_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> $past(!ce_n && we_n && !oe_n && !pwr_fail));

   a_r3_we_overrides_oe: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |=> !dq_oe);

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr |=> !arr_wr);

   a_r5_refused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> (!arr_rd && !dq_oe));

   a_r8_lockout: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> (!arr_rd && !arr_wr && !dq_oe));

   a_r9_no_commit_in_fail: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr |-> $past(!pwr_fail));

   a_r10_rst_low: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> !rst_out_n);

   a_r10_rst_high: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_fail |=> rst_out_n);

endmodule

bind nvbus_gate nvbg_chk i_chk (.*);

// File: tb/test_nvbus_gate.sv
`timescale 1ns/1ps
module test_nvbus_gate;

   localparam int AW  = 6;
   localparam int DW  = 8;
   localparam int REC = 3;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, pwr_fail = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dq_out, arr_wdata, arr_rdata;
   logic [AW-1:0] arr_addr;
   logic          dq_oe, arr_rd, arr_wr, acc_err, rst_out_n;

   int total = 0;
   int bad = 0;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] shadow [DEPTH];

   always #4 clk = ~clk;

   nvbus_gate #(.AW(AW), .DW(DW), .REC_CYC(REC)) i_nvbus_gate (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .pwr_fail(pwr_fail), .addr(addr), .din(din), .dq_out(dq_out),
      .dq_oe(dq_oe), .arr_addr(arr_addr), .arr_rd(arr_rd), .arr_wr(arr_wr),
      .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .acc_err(acc_err),
      .rst_out_n(rst_out_n)
   );

   // array model the gate fronts
   assign arr_rdata = mem[arr_addr];
   always @(posedge clk) if (arr_wr) mem[arr_addr] <= arr_wdata;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // open a write (ce_first picks which enable falls first), close it,
   // then wait out the recovery interval
   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ce_first);
      addr = a; din = d;
      if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
      step();
      ce_n = 1'b0; we_n = 1'b0;
      step();
      step();
      ce_n = 1'b1; we_n = 1'b1;
      repeat (REC) step();
      shadow[a] = d;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic oe_seen, output logic [DW-1:0] q);
      addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
      step();
      oe_seen = dq_oe; q = dq_out;
      ce_n = 1'b1; oe_n = 1'b1;
      step();
   endtask

   function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
      return shadow[a];
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic          oe_s;
      logic [DW-1:0] q;
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; shadow[i] = '0; end

      // reset state
      repeat (3) step();
      chk("R11 arr_rd in reset", arr_rd, 0);
      chk("R11 arr_wr in reset", arr_wr, 0);
      chk("R11 dq_oe in reset", dq_oe, 0);
      chk("R11 acc_err in reset", acc_err, 0);
      chk("R11 rst_out_n in reset", rst_out_n, 0);
      rst_n = 1'b1;
      step();
      chk("R10 rst_out_n after reset, supply good", rst_out_n, 1);

      // directed commit pulse check
      addr = 6'd5; din = 8'hA5; we_n = 1'b0;
      step();
      chk("R4 no strobe while only WE low", arr_wr, 0);
      ce_n = 1'b0;
      step(); step();
      chk("R4 no commit while window open", arr_wr, 0);
      ce_n = 1'b1; we_n = 1'b1;
      step();
      chk("R4 commit pulse", arr_wr, 1);
      chk("R4 commit address", arr_addr, 6'd5);
      chk("R4 commit data", arr_wdata, 8'hA5);
      step();
      chk("R4 pulse is one clock", arr_wr, 0);
      shadow[5] = 8'hA5;
      repeat (REC - 1) step();

      bus_write(6'd9, 8'h3C, 1'b1);
      bus_read(6'd5, oe_s, q);
      chk("R2 read drives bus", oe_s, 1);
      chk("R1 read data loc 5", q, expect_rd(6'd5));

      // output enable held high: strobe but no drive
      addr = 6'd9; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
      step();
      chk("R1 arr_rd with OE high", arr_rd, 1);
      chk("R2 no drive with OE high", dq_oe, 0);
      ce_n = 1'b1;
      step();

      // address ripple during read, then WE override
      addr = 6'd5; ce_n = 1'b0; oe_n = 1'b0;
      step();
      chk("R7 first location", dq_out, 8'hA5);
      addr = 6'd9;
      #1;
      chk("R7 old data before edge", dq_out, 8'hA5);
      step();
      chk("R7 new data after edge", dq_out, 8'h3C);
      din = 8'h5A; we_n = 1'b0;
      step();
      chk("R3 WE low releases bus", dq_oe, 0);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      step();
      chk("R4 write after override commits", arr_wr, 1);
      shadow[9] = 8'h5A;
      repeat (REC - 1) step();

      // early access refused
      addr = 6'd12; din = 8'h77; ce_n = 1'b0; we_n = 1'b0;
      step(); step();
      ce_n = 1'b1; we_n = 1'b1;
      repeat (REC - 1) step();
      shadow[12] = 8'h77;
      addr = 6'd12; ce_n = 1'b0; oe_n = 1'b0;
      step();
      chk("R5 early access flagged", acc_err, 1);
      chk("R5 early access no drive", dq_oe, 0);
      chk("R5 early access no strobe", arr_rd, 0);
      step();
      chk("R5 flag is one clock", acc_err, 0);
      chk("R5 refused until CE high", dq_oe, 0);
      ce_n = 1'b1; oe_n = 1'b1;
      step();
      bus_read(6'd12, oe_s, q);
      chk("R6 later access accepted", oe_s, 1);
      chk("R6 later access data", q, 8'h77);

      // exact boundary: REC edges after commit edge
      addr = 6'd20; din = 8'hC3; ce_n = 1'b0; we_n = 1'b0;
      step(); step();
      ce_n = 1'b1; we_n = 1'b1;
      repeat (REC) step();
      shadow[20] = 8'hC3;
      addr = 6'd20; ce_n = 1'b0; oe_n = 1'b0;
      step();
      chk("R6 boundary no flag", acc_err, 0);
      chk("R6 boundary drive", dq_oe, 1);
      chk("R6 boundary data", dq_out, 8'hC3);
      ce_n = 1'b1; oe_n = 1'b1;
      step();

      // supply fail aborts open write
      addr = 6'd20; din = 8'h11; ce_n = 1'b0; we_n = 1'b0;
      step();
      pwr_fail = 1'b1;
      step();
      chk("R10 reset out low in fail", rst_out_n, 0);
      chk("R9 no commit on fail", arr_wr, 0);
      ce_n = 1'b1; we_n = 1'b1;
      step();
      chk("R9 no commit after window closes", arr_wr, 0);
      ce_n = 1'b0; oe_n = 1'b0;
      step();
      chk("R8 read blocked in fail", arr_rd, 0);
      chk("R8 no drive in fail", dq_oe, 0);
      chk("R10 reset out held", rst_out_n, 0);
      ce_n = 1'b1; oe_n = 1'b1;
      step();
      pwr_fail = 1'b0;
      step();
      chk("R10 reset out released", rst_out_n, 1);
      bus_read(6'd20, oe_s, q);
      chk("R9 old contents kept", q, 8'hC3);

      // constrained random write/readback
      for (int i = 0; i < 30; i++) begin
         logic [AW-1:0] a, b;
         logic [DW-1:0] d;
         a = AW'($urandom_range(0, DEPTH - 1));
         d = DW'($urandom);
         bus_write(a, d, bit'($urandom_range(0, 1)));
         b = ($urandom_range(0, 1) == 1) ? a : AW'($urandom_range(0, DEPTH - 1));
         bus_read(b, oe_s, q);
         chk("R6 random access accepted", oe_s, 1);
         chk("R1 random readback", q, expect_rd(b));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule